// File: doc/BRIEF.md
# Pulse Response Tap Extractor

This block measures the sampled response of a channel to one isolated test symbol and turns it into the post-cursor weights a decision feedback equalizer needs. On a start request it first watches one quiet symbol and takes a baseline sample from the channel output. It then drives a single pulse, one symbol long and of the programmed signed amplitude, onto its channel-drive port. After that it keeps taking one sample per symbol.

The block runs on an oversampled tick clock with sixteen ticks per symbol. The sampling phase selects which tick inside each symbol is captured, so the capture point can be placed on the pulse peak. Every capture is taken relative to the baseline. The first capture whose magnitude is above the threshold is treated as pre-cursor interference and the second as the main cursor. The captures of the symbols that follow are written in order into the tap file as h1 to hN. When the last tap is written, done rises. If no main cursor appears within 256 symbols, the block raises an error flag instead and leaves the taps at zero.

Top module: `pulse_tap_extractor`

## Requirements
- R1: While reset is held and after its release, pulseOut is zero, done and error are low and every tap reads zero.
- R2: A start seen at a clock edge is followed by exactly 16 ticks of zero drive (the quiet symbol), then exactly 16 ticks with pulseOut equal to the latched amplitude, then zero drive again.
- R3: One sample is captured per symbol, at the tick whose index inside the symbol (0 to 15, counted from the first tick of the symbol) equals the phase setting latched at start.
- R4: The capture in the quiet symbol is the baseline. Every later capture is used as its signed difference from that baseline, so a nonzero channel offset does not change the tap values.
- R5: A capture counts as nonzero only when the magnitude of its difference is strictly greater than the threshold latched at start.
- R6: The first nonzero capture is skipped as pre-cursor and the second is taken as the main cursor. The differences of the NTAPS captures in the symbols right after the main cursor are stored as h1..hN, whatever their size. Tap k sits in taps[k*TAP_W-1 -: TAP_W] as signed two's complement with TAP_W = SAMPLE_W+1.
- R7: done rises once the last tap is written and stays high until the next start.
- R8: If the main cursor has not been found by the end of the 256th symbol, counted from the pulse symbol, done and error both go high and all taps stay zero.
- R9: A start at any time, including in the middle of a measurement, clears the taps, done and error at the next edge and restarts the sequence. Amplitude, phase and threshold are latched at start, so later changes on those inputs have no effect on the current measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled tick clock, 16 ticks per symbol |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts or restarts a measurement |
| pulseAmp | input | SAMPLE_W | Signed test-pulse amplitude |
| phaseSel | input | 4 | Sampling tick within each symbol |
| threshold | input | SAMPLE_W | Unsigned detection threshold on magnitude |
| sampleIn | input | SAMPLE_W | Signed channel output, one value per tick |
| pulseOut | output | SAMPLE_W | Signed drive into the channel input |
| taps | output | NTAPS*(SAMPLE_W+1) | Packed tap file h1..hN, h1 in the low bits |
| done | output | 1 | Measurement finished |
| error | output | 1 | Main cursor not found before the timeout |

## Verification
The hardest state to reach is a restart that lands after some taps have already been written but before done rises. Reaching it needs the channel response to be fed back in step with the block's own pulse. The bench therefore models the channel as a function of the tick index since the drive went nonzero, with the peak on one chosen tick. It issues a second start about 80 ticks into a run, checks that partial taps are visible, and then checks that the second run starts from a cleared file with its own settings. Threshold equality, off-peak phase, a zero-valued tap between nonzero ones, and a silent channel that runs all 256 symbols are reached by choosing the channel coefficients and settings.

// File: rtl/pte_pkg.sv
package pte_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BASE,
    ST_PULSE,
    ST_SCAN,
    ST_FIN
  } pte_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearAll;
    logic captureBase;
    logic captureSample;
  } pte_strobe_t;

endpackage

// File: rtl/pte_ctrl.sv
module pte_ctrl
  import pte_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int PHASES   = 16,
  parameter int TIMEOUT  = 256
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       start,
  input  logic signed [SAMPLE_W-1:0] pulseAmp,
  input  logic [$clog2(PHASES)-1:0]  phaseSel,
  input  logic                       mainSeen,
  input  logic                       allStored,
  output pte_strobe_t                strobes,
  output logic signed [SAMPLE_W-1:0] pulseOut,
  output logic                       done,
  output logic                       error
);

  localparam int PW  = $clog2(PHASES);
  localparam int SCW = $clog2(TIMEOUT + 1);
  localparam logic [PW-1:0]  LAST_TICK = PW'(PHASES - 1);
  localparam logic [SCW-1:0] SYM_LIMIT = SCW'(TIMEOUT);

  pte_state_t                 state;
  logic [PW-1:0]              phaseCnt;
  logic [PW-1:0]              phaseReg;
  logic [SCW-1:0]             symCnt;
  logic signed [SAMPLE_W-1:0] ampReg;
  logic                       errReg;
  logic                       lastTick;
  logic                       pulseActive;

  assign lastTick    = (phaseCnt == LAST_TICK);
  assign pulseActive = (state == ST_PULSE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      phaseReg <= '0;
      symCnt   <= '0;
      ampReg   <= '0;
      errReg   <= 1'b0;
    end else if (start) begin
      state    <= ST_BASE;
      phaseCnt <= '0;
      phaseReg <= phaseSel;
      symCnt   <= '0;
      ampReg   <= pulseAmp;
      errReg   <= 1'b0;
    end else begin
      case (state)
        ST_BASE: begin
          phaseCnt <= lastTick ? '0 : phaseCnt + 1'b1;
          if (lastTick) state <= ST_PULSE;
        end
        ST_PULSE: begin
          phaseCnt <= lastTick ? '0 : phaseCnt + 1'b1;
          if (lastTick) begin
            state  <= ST_SCAN;
            symCnt <= symCnt + 1'b1;
          end
        end
        ST_SCAN: begin
          phaseCnt <= lastTick ? '0 : phaseCnt + 1'b1;
          if (lastTick && symCnt != SYM_LIMIT) symCnt <= symCnt + 1'b1;
          if (allStored) begin
            state <= ST_FIN;
          end else if (symCnt == SYM_LIMIT && !mainSeen) begin
            state  <= ST_FIN;
            errReg <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobes.clearAll      = start;
    strobes.captureBase   = (state == ST_BASE) && (phaseCnt == phaseReg) && !start;
    strobes.captureSample = (state == ST_PULSE || state == ST_SCAN) &&
                            (phaseCnt == phaseReg) && !start;
  end

  assign pulseOut = pulseActive ? ampReg : '0;
  assign done     = (state == ST_FIN);
  assign error    = errReg;

  // R7: done holds until a new start
  assert_done_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    done && !start |=> done);

  // R8: error is only ever seen together with done
  assert_error_with_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> done);

  // R2: drive begins on the first tick of a symbol
  assert_pulse_aligned_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pulseActive) |-> phaseCnt == '0);

  // R2: drive ends after the last tick of its symbol
  assert_pulse_one_symbol_R2: assert property (@(posedge clk) disable iff (!rstN)
    pulseActive && lastTick && !start |=> !pulseActive);

endmodule

// File: rtl/pte_datapath.sv
module pte_datapath
  import pte_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int NTAPS    = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  pte_strobe_t                        strobes,
  input  logic signed [SAMPLE_W-1:0]         sampleIn,
  input  logic [SAMPLE_W-1:0]                threshold,
  output logic                               mainSeen,
  output logic                               allStored,
  output logic [NTAPS*(SAMPLE_W+1)-1:0]      taps
);

  localparam int TAP_W = SAMPLE_W + 1;
  localparam int IDX_W = $clog2(NTAPS + 1);
  localparam logic [IDX_W-1:0] IDX_FULL = IDX_W'(NTAPS);

  logic signed [SAMPLE_W-1:0] baseline;
  logic [SAMPLE_W-1:0]        thrReg;
  logic                       preSeen;
  logic [IDX_W-1:0]           tapIdx;
  logic signed [TAP_W-1:0]    diff;
  logic [TAP_W-1:0]           mag;
  logic                       hit;
  logic                       writeTap;
  logic signed [TAP_W-1:0]    tapFile [NTAPS];

  always_comb begin
    diff = TAP_W'(sampleIn) - TAP_W'(baseline);
    mag  = diff[TAP_W-1] ? TAP_W'(-diff) : TAP_W'(diff);
    hit  = mag > {1'b0, thrReg};
  end

  assign writeTap  = strobes.captureSample && mainSeen && (tapIdx < IDX_FULL);
  assign allStored = (tapIdx == IDX_FULL);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseline <= '0;
      thrReg   <= '0;
      preSeen  <= 1'b0;
      mainSeen <= 1'b0;
      tapIdx   <= '0;
    end else if (strobes.clearAll) begin
      baseline <= '0;
      thrReg   <= threshold;
      preSeen  <= 1'b0;
      mainSeen <= 1'b0;
      tapIdx   <= '0;
    end else begin
      if (strobes.captureBase) baseline <= sampleIn;
      if (strobes.captureSample && !mainSeen && hit) begin
        if (preSeen) mainSeen <= 1'b1;
        else         preSeen  <= 1'b1;
      end
      if (writeTap) tapIdx <= tapIdx + 1'b1;
    end
  end

  for (genvar i = 0; i < NTAPS; i++) begin : g_tap
    always_ff @(posedge clk) begin
      if (!rstN || strobes.clearAll) begin
        tapFile[i] <= '0;
      end else if (writeTap && tapIdx == IDX_W'(i)) begin
        tapFile[i] <= diff;
      end
    end
    assign taps[i*TAP_W +: TAP_W] = tapFile[i];
  end

  // R6: no tap is written before the main cursor
  assert_no_tap_before_main_R6: assert property (@(posedge clk) disable iff (!rstN)
    !mainSeen |-> tapIdx == '0);

  // R6: the write index never passes the tap count
  assert_idx_bound_R6: assert property (@(posedge clk) disable iff (!rstN)
    tapIdx <= IDX_FULL);

  // R5: the main cursor is only found after a pre-cursor
  assert_main_after_pre_R5: assert property (@(posedge clk) disable iff (!rstN)
    mainSeen |-> preSeen);

endmodule

// File: rtl/pulse_tap_extractor.sv
module pulse_tap_extractor
  import pte_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int NTAPS    = 4,
  parameter int PHASES   = 16,
  parameter int TIMEOUT  = 256
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              start,
  input  logic signed [SAMPLE_W-1:0]        pulseAmp,
  input  logic [$clog2(PHASES)-1:0]         phaseSel,
  input  logic [SAMPLE_W-1:0]               threshold,
  input  logic signed [SAMPLE_W-1:0]        sampleIn,
  output logic signed [SAMPLE_W-1:0]        pulseOut,
  output logic [NTAPS*(SAMPLE_W+1)-1:0]     taps,
  output logic                              done,
  output logic                              error
);

  pte_strobe_t strobes;
  logic        mainSeen;
  logic        allStored;

  pte_ctrl #(
    .SAMPLE_W (SAMPLE_W),
    .PHASES   (PHASES),
    .TIMEOUT  (TIMEOUT)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .pulseAmp  (pulseAmp),
    .phaseSel  (phaseSel),
    .mainSeen  (mainSeen),
    .allStored (allStored),
    .strobes   (strobes),
    .pulseOut  (pulseOut),
    .done      (done),
    .error     (error)
  );

  pte_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .NTAPS    (NTAPS)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .sampleIn  (sampleIn),
    .threshold (threshold),
    .mainSeen  (mainSeen),
    .allStored (allStored),
    .taps      (taps)
  );

  // R9: a start clears the results at the next edge
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    start |=> !done && !error && taps == '0);

  // R8: an error leaves the tap file empty
  assert_error_taps_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    error |-> taps == '0);

endmodule

// File: tb/pulse_tap_extractor_bench.sv
module pulse_tap_extractor_bench;

  localparam int CLK_PERIOD = 10;
  localparam int W    = 12;
  localparam int NT   = 4;
  localparam int TW   = W + 1;
  localparam int PEAK = 5;

  logic                 clk = 1'b0;
  logic                 rstN;
  logic                 start;
  logic signed [W-1:0]  pulseAmp;
  logic [3:0]           phaseSel;
  logic [W-1:0]         threshold;
  logic signed [W-1:0]  sampleIn;
  logic signed [W-1:0]  pulseOut;
  logic [NT*TW-1:0]     taps;
  logic                 done;
  logic                 error;

  pulse_tap_extractor u_pulse_tap_extractor (
    .clk(clk), .rstN(rstN), .start(start), .pulseAmp(pulseAmp),
    .phaseSel(phaseSel), .threshold(threshold), .sampleIn(sampleIn),
    .pulseOut(pulseOut), .taps(taps), .done(done), .error(error)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;

  typedef struct {
    int    tap [NT];
    bit    err;
    string req;
  } exp_t;
  exp_t expQ[$];

  // channel model state
  int chanMode = 0;
  int chanAmp  = 0;
  int baseVal  = 0;
  int runId    = 0;
  int seenRun  = 0;
  bit running  = 0;
  int tick     = 0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int coef(int mode, int k);
    if (mode == 0) begin
      case (k)
        0: return 4;  1: return 64; 2: return 32;
        3: return -12; 4: return 8; 5: return -4;
        default: return 0;
      endcase
    end else if (mode == 2) begin
      case (k)
        1: return 6;  2: return 64; 3: return -20;
        4: return 10; 6: return 5;
        default: return 0;
      endcase
    end
    return 0;
  endfunction

  // response at symbol k, tick p; peak only on tick PEAK, half elsewhere
  function automatic int resp(int mode, int amp, int k, int p);
    int prod;
    prod = amp * coef(mode, k);
    return (p == PEAK) ? (prod >>> 6) : (prod >>> 7);
  endfunction

  function automatic exp_t model(int mode, int amp, int phase, int thr, string req);
    exp_t e;
    int hits;
    int idx;
    int d;
    int mag;
    hits = 0;
    idx  = 0;
    for (int i = 0; i < NT; i++) e.tap[i] = 0;
    for (int k = 0; k < 300; k++) begin
      d = resp(mode, amp, k, phase);
      mag = (d < 0) ? -d : d;
      if (hits < 2) begin
        if (k < 256 && mag > thr) hits++;
      end else if (idx < NT) begin
        e.tap[idx] = d;
        idx++;
      end
    end
    e.err = (hits < 2);
    if (e.err) for (int i = 0; i < NT; i++) e.tap[i] = 0;
    e.req = req;
    return e;
  endfunction

  // channel: applies response relative to first driven tick
  always @(negedge clk) begin
    if (seenRun != runId) begin
      seenRun = runId;
      running = 0;
    end
    if (!running && pulseOut != '0) begin
      running = 1;
      tick = 0;
    end
    if (running) begin
      sampleIn <= W'(baseVal + resp(chanMode, chanAmp, tick / 16, tick % 16));
      tick++;
    end else begin
      sampleIn <= W'(baseVal);
    end
  end

  // monitor: pops expected results when done rises
  initial begin
    forever begin
      @(posedge done);
      @(negedge clk);
      if (expQ.size() == 0) begin
        check(0, "R7", "unexpected done", 1, 0);
      end else begin
        exp_t e;
        e = expQ.pop_front();
        check(error == e.err, e.err ? "R8" : e.req, "error flag", int'(error), int'(e.err));
        for (int i = 0; i < NT; i++) begin
          int act;
          act = int'($signed(taps[i*TW +: TW]));
          check(act == e.tap[i], e.err ? "R8" : e.req, $sformatf("tap h%0d", i + 1), act, e.tap[i]);
        end
      end
    end
  end

  task automatic launch(int mode, int amp, int phase, int thr, int base);
    @(negedge clk);
    runId++;
    chanMode  = mode;
    chanAmp   = amp;
    baseVal   = base;
    pulseAmp  = W'(amp);
    phaseSel  = 4'(phase);
    threshold = W'(thr);
    start     = 1'b1;
    @(negedge clk);
    start     = 1'b0;
    // change settings after start: must have no effect (R9)
    pulseAmp  = W'(-amp + 7);
    phaseSel  = 4'(phase + 3);
    threshold = '0;
  endtask

  task automatic runTest(int mode, int amp, int phase, int thr, int base, string req);
    bit ok;
    int bad;
    expQ.push_back(model(mode, amp, phase, thr, req));
    launch(mode, amp, phase, thr, base);
    check(taps == '0 && !done && !error, "R9", "cleared after start",
          int'(done) + int'(error), 0);
    ok = 1; bad = 0;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      if (pulseOut != '0) begin ok = 0; bad = int'(pulseOut); end
    end
    check(ok, "R2", "quiet symbol drive", bad, 0);
    ok = 1; bad = amp;
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      if (int'(pulseOut) != amp) begin ok = 0; bad = int'(pulseOut); end
    end
    check(ok, "R2", "pulse drive", bad, amp);
    @(negedge clk);
    check(pulseOut == '0, "R2", "drive after pulse", int'(pulseOut), 0);
    wait (expQ.size() == 0);
    repeat (6) @(negedge clk);
    check(done == 1'b1, "R7", "done holds", int'(done), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rstN      = 1'b0;
    start     = 1'b0;
    pulseAmp  = '0;
    phaseSel  = '0;
    threshold = '0;
    repeat (3) @(negedge clk);
    check(pulseOut == '0 && !done && !error && taps == '0, "R1", "reset state",
          int'(done) + int'(error) + int'(pulseOut != '0) + int'(taps != '0), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(pulseOut == '0 && !done && !error && taps == '0, "R1", "idle after reset",
          int'(done) + int'(error), 0);

    // R6: nominal extraction at the peak tick
    runTest(0, 200, PEAK, 5, 100, "R6");
    // R3: off-peak phase reads the half-size response
    runTest(0, 200, 9, 5, 100, "R3");
    // R5: threshold above pre-cursor shifts the positions
    runTest(0, 200, PEAK, 20, -50, "R5");
    // R5: magnitude equal to threshold does not count
    runTest(0, 200, PEAK, 12, 100, "R5");
    // R4: negative amplitude on a negative baseline, zero tap in the middle
    runTest(2, -150, PEAK, 5, -300, "R4");

    // R9: restart in the middle of a run with partial taps present
    launch(0, 200, PEAK, 5, 100);
    repeat (80) @(negedge clk);
    check(!done, "R9", "mid-run not done", int'(done), 0);
    check(taps[TW-1:0] != '0, "R6", "partial h1 present", int'($signed(taps[TW-1:0])), 100);
    runTest(2, 300, PEAK, 5, 50, "R9");

    // R8: silent channel times out
    runTest(1, 100, PEAK, 5, 0, "R8");
    // recovery after error
    runTest(0, 200, PEAK, 5, 100, "R6");

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule